// File: doc/BRIEF.md
# DMA Snoop Controller with Duplicate Tags

This block keeps a direct-mapped data cache consistent with main memory while a DMA engine moves I/O data across the shared bus. It holds a private copy of the cache tags (valid, modified and address tag per line) and uses it only for snooping. Processor lookups therefore never compete with bus snooping for a tag read port. The processor side reports every line fill, line invalidation and line modification to the block, so the private copy always matches the real tags.

A bus address is captured in one cycle and judged in the next. A DMA input (device data written to memory) that hits in the copied tags makes the block order the cache to take the same data, so the line and memory both receive it. A DMA output (memory read by a device) that hits makes the block drop the line when the cache runs write-through. When the cache runs write-back, the block orders the line to supply the data, raises a memory-inhibit strobe for that transfer, and then drops the line. A miss leaves the cache alone and memory serves the transfer. When a snoop action and a processor tag update target the same line in one cycle, the snoop wins and the processor is told to retry.

Top module: `dma_snoop_ctrl`

## Requirements
- R1: After reset every copied tag entry is invalid, and cmd_valid, mem_inhibit and cpu_retry are 0 until a bus request hits.
- R2: A bus request presented with bus_valid=1 in cycle t produces its command, if any, in cycle t+1 and in no other cycle. cmd_valid is never 1 in a cycle that does not follow a bus_valid=1 cycle.
- R3: A DMA input (bus_dir=1) whose address hits gives cmd_op=2'b01 (update cache and memory), and the line stays valid, so a later snoop of the same address still hits.
- R4: A DMA output (bus_dir=0) that hits while wb_mode=0 gives cmd_op=2'b10 (invalidate) with mem_inhibit=0, and a later snoop of that address misses.
- R5: A DMA output that hits while wb_mode=1 gives cmd_op=2'b11 (cache supplies data), and the line is invalid afterwards.
- R6: A hit requires the entry at index bus_addr[9:4] to be valid with its tag equal to bus_addr[31:10]. On a miss, cmd_valid=0, mem_inhibit=0, and the tag copy is unchanged.
- R7: A processor tag update (cpu_op 2'b01 fill with tag from cpu_addr and clean, 2'b10 invalidate, 2'b11 mark modified if valid; index cpu_addr[9:4]) takes effect at the clock edge ending its cycle, so a snoop judged in the next cycle sees it.
- R8: If a snoop hits in the same cycle that a processor update targets the same index, cpu_retry=1 and the processor update is discarded. Updates to other indices, or updates during a snoop miss, proceed with cpu_retry=0.
- R9: With each command, cmd_idx equals the index of the snooped address and cmd_dirty equals the modified bit of the hit line.
- R10: mem_inhibit is 1 exactly in the cycles where cmd_valid=1 and cmd_op=2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_mode | input | 1 | 1 = cache runs write-back, 0 = write-through |
| bus_valid | input | 1 | A DMA transfer address is on the bus |
| bus_dir | input | 1 | 1 = DMA input (write to memory), 0 = DMA output (read from memory) |
| bus_addr | input | 32 | Bus transfer address |
| cpu_op | input | 2 | Processor tag update: 0 none, 1 fill, 2 invalidate, 3 mark modified |
| cpu_addr | input | 32 | Address of the processor tag update |
| cmd_valid | output | 1 | A command to the cache data array is issued |
| cmd_op | output | 2 | 1 update, 2 invalidate, 3 supply-then-invalidate |
| cmd_idx | output | 6 | Cache line index of the command |
| cmd_dirty | output | 1 | Modified bit of the hit line |
| mem_inhibit | output | 1 | Memory must not respond; the cache supplies the data |
| cpu_retry | output | 1 | Processor tag update discarded this cycle; retry it |

## Verification
The two functions that can fall in one cycle are the snoop judgement of a captured bus address and a processor tag update. The bench provokes this collision by issuing a processor fill, invalidate or mark on the very index being judged, on other indices, and during hits as well as misses. It also runs a long stretch with random operations confined to four indices and two tags. A reference model in the bench applies the snoop-wins rule independently and compares cpu_retry and all command outputs every cycle. Later snoops of the same address then show whether the discarded or applied processor update really took effect.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
   typedef enum logic [1:0] {
      SNP_NONE   = 2'b00,
      SNP_UPDATE = 2'b01,
      SNP_INVAL  = 2'b10,
      SNP_SUPPLY = 2'b11
   } snp_cmd_e;

   typedef enum logic [1:0] {
      CPU_NOP   = 2'b00,
      CPU_FILL  = 2'b01,
      CPU_INVAL = 2'b10,
      CPU_DIRTY = 2'b11
   } cpu_op_e;
endpackage

// File: rtl/snoop_tag_store.sv
module snoop_tag_store
   import snoop_pkg::*;
#(
   parameter int LINES = 64,
   parameter int TAG_W = 22,
   localparam int IW   = $clog2(LINES)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IW-1:0]    rd_idx,
   output logic             rd_valid,
   output logic             rd_dirty,
   output logic [TAG_W-1:0] rd_tag,
   input  logic             snp_clr,
   input  logic [IW-1:0]    snp_idx,
   input  logic             cpu_we,
   input  logic [1:0]       cpu_op,
   input  logic [IW-1:0]    cpu_idx,
   input  logic [TAG_W-1:0] cpu_tag
);
   logic [LINES-1:0] valid_q;
   logic [LINES-1:0] dirty_q;
   logic [TAG_W-1:0] tag_q [LINES];

   genvar g;
   generate
      for (g = 0; g < LINES; g++) begin : g_line
         logic sel_snp, sel_cpu;
         assign sel_snp = snp_clr && (snp_idx == IW'(g));
         assign sel_cpu = cpu_we && (cpu_idx == IW'(g)) && !sel_snp;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               valid_q[g] <= 1'b0;
               dirty_q[g] <= 1'b0;
               tag_q[g]   <= '0;
            end else if (sel_snp) begin
               valid_q[g] <= 1'b0;
               dirty_q[g] <= 1'b0;
            end else if (sel_cpu) begin
               unique case (cpu_op)
                  CPU_FILL: begin
                     valid_q[g] <= 1'b1;
                     dirty_q[g] <= 1'b0;
                     tag_q[g]   <= cpu_tag;
                  end
                  CPU_INVAL: begin
                     valid_q[g] <= 1'b0;
                     dirty_q[g] <= 1'b0;
                  end
                  CPU_DIRTY: dirty_q[g] <= valid_q[g];
                  default: ;
               endcase
            end
         end
      end
   endgenerate

   assign rd_valid = valid_q[rd_idx];
   assign rd_dirty = dirty_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];

   // R4
   snoop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_clr |=> !valid_q[$past(snp_idx)]);

   // R7
   cpu_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we && cpu_op == CPU_FILL && !(snp_clr && snp_idx == cpu_idx))
      |=> (valid_q[$past(cpu_idx)] && tag_q[$past(cpu_idx)] == $past(cpu_tag)));
endmodule

// File: rtl/snoop_decide.sv
module snoop_decide
   import snoop_pkg::*;
#(
   parameter int TAG_W = 22
)(
   input  logic             req_v,
   input  logic             req_dir,
   input  logic [TAG_W-1:0] req_tag,
   input  logic             wb_mode,
   input  logic             rd_valid,
   input  logic [TAG_W-1:0] rd_tag,
   output logic             hit,
   output logic [1:0]       op,
   output logic             inhibit,
   output logic             clr
);
   always_comb begin
      hit     = req_v && rd_valid && (rd_tag == req_tag);
      op      = SNP_NONE;
      inhibit = 1'b0;
      clr     = 1'b0;
      if (hit) begin
         if (req_dir) begin
            op = SNP_UPDATE;
         end else if (wb_mode) begin
            op      = SNP_SUPPLY;
            inhibit = 1'b1;
            clr     = 1'b1;
         end else begin
            op  = SNP_INVAL;
            clr = 1'b1;
         end
      end
   end
endmodule

// File: rtl/dma_snoop_ctrl.sv
module dma_snoop_ctrl
   import snoop_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 16,
   parameter int NUM_LINES  = 64
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wb_mode,
   input  logic                         bus_valid,
   input  logic                         bus_dir,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [1:0]                   cpu_op,
   input  logic [ADDR_W-1:0]            cpu_addr,
   output logic                         cmd_valid,
   output logic [1:0]                   cmd_op,
   output logic [$clog2(NUM_LINES)-1:0] cmd_idx,
   output logic                         cmd_dirty,
   output logic                         mem_inhibit,
   output logic                         cpu_retry
);
   localparam int OFF_W = $clog2(LINE_BYTES);
   localparam int IDX_W = $clog2(NUM_LINES);
   localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

   generate
      if ((1 << OFF_W) != LINE_BYTES) begin : g_bad_line
         $error("LINE_BYTES must be a power of two");
      end
      if ((1 << IDX_W) != NUM_LINES) begin : g_bad_lines
         $error("NUM_LINES must be a power of two");
      end
      if (TAG_W < 1) begin : g_bad_addr
         $error("ADDR_W too small for the cache geometry");
      end
   endgenerate

   // captured bus request, judged one cycle later
   logic              req_v, req_dir;
   logic [ADDR_W-1:0] req_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_v    <= 1'b0;
         req_dir  <= 1'b0;
         req_addr <= '0;
      end else begin
         req_v <= bus_valid;
         if (bus_valid) begin
            req_dir  <= bus_dir;
            req_addr <= bus_addr;
         end
      end
   end

   logic [IDX_W-1:0] req_idx, cpu_idx;
   logic [TAG_W-1:0] req_tag, cpu_tag, rd_tag;
   logic             rd_valid, rd_dirty, hit, clr, inhibit, cpu_we;
   logic [1:0]       op;

   assign req_idx = req_addr[OFF_W +: IDX_W];
   assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
   assign cpu_idx = cpu_addr[OFF_W +: IDX_W];
   assign cpu_tag = cpu_addr[ADDR_W-1 -: TAG_W];

   snoop_decide #(.TAG_W(TAG_W)) u_decide (
      .req_v(req_v), .req_dir(req_dir), .req_tag(req_tag), .wb_mode(wb_mode),
      .rd_valid(rd_valid), .rd_tag(rd_tag),
      .hit(hit), .op(op), .inhibit(inhibit), .clr(clr)
   );

   // snoop action beats a processor update of the same line
   assign cpu_retry = hit && (cpu_op != CPU_NOP) && (cpu_idx == req_idx);
   assign cpu_we    = (cpu_op != CPU_NOP) && !cpu_retry;

   snoop_tag_store #(.LINES(NUM_LINES), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(req_idx), .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag),
      .snp_clr(clr), .snp_idx(req_idx),
      .cpu_we(cpu_we), .cpu_op(cpu_op), .cpu_idx(cpu_idx), .cpu_tag(cpu_tag)
   );

   assign cmd_valid   = hit;
   assign cmd_op      = op;
   assign cmd_idx     = req_idx;
   assign cmd_dirty   = hit && rd_dirty;
   assign mem_inhibit = inhibit;

   // R2
   decide_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $past(bus_valid));

   // R10
   inhibit_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_inhibit == (cmd_valid && cmd_op == SNP_SUPPLY));

   // R5
   supply_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == SNP_SUPPLY) |-> (wb_mode && !$past(bus_dir)));

   // R8
   retry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_retry |-> (cmd_valid && cpu_op != CPU_NOP && cpu_idx == cmd_idx));

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      $past(!rst_n) |-> (!cmd_valid && !mem_inhibit && !cpu_retry));
endmodule

// File: tb/sim_dma_snoop_ctrl.sv
module sim_dma_snoop_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wb_mode = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_dir = 1'b0;
   logic [31:0] bus_addr = '0;
   logic [1:0]  cpu_op = '0;
   logic [31:0] cpu_addr = '0;
   logic        cmd_valid, cmd_dirty, mem_inhibit, cpu_retry;
   logic [1:0]  cmd_op;
   logic [5:0]  cmd_idx;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #10 clk = ~clk;

   dma_snoop_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode),
      .bus_valid(bus_valid), .bus_dir(bus_dir), .bus_addr(bus_addr),
      .cpu_op(cpu_op), .cpu_addr(cpu_addr),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
      .cmd_dirty(cmd_dirty), .mem_inhibit(mem_inhibit), .cpu_retry(cpu_retry)
   );

   // behavioural reference state
   bit          m_valid [64];
   bit          m_dirty [64];
   int unsigned m_tag   [64];
   bit          m_sv = 0;
   bit          m_sdir = 0;
   logic [31:0] m_saddr = '0;

   task automatic check(string req, int unsigned act, int unsigned exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // one cycle: drive, compare against model, advance model at the edge
   task automatic step(bit bv, bit bd, logic [31:0] ba, logic [1:0] co,
                       logic [31:0] ca, string tag);
      int          idx, cidx;
      int unsigned tg;
      bit          hit, rty;
      logic [1:0]  eop;
      @(negedge clk);
      bus_valid = bv; bus_dir = bd; bus_addr = ba; cpu_op = co; cpu_addr = ca;
      #5;
      idx  = int'(m_saddr[9:4]);
      tg   = m_saddr[31:10];
      cidx = int'(ca[9:4]);
      hit  = m_sv && m_valid[idx] && (m_tag[idx] == tg);
      eop  = !hit ? 2'b00 : (m_sdir ? 2'b01 : (wb_mode ? 2'b11 : 2'b10));
      rty  = hit && (co != 2'b00) && (cidx == idx);
      check(hit ? tag : "R6", cmd_valid, hit);
      if (hit) begin
         check(m_sdir ? "R3" : (wb_mode ? "R5" : "R4"), cmd_op, eop);
         check("R9", cmd_idx, idx);
         check("R9", cmd_dirty, m_dirty[idx]);
      end
      check("R10", mem_inhibit, (eop == 2'b11));
      check("R8", cpu_retry, rty);
      @(posedge clk);
      if (hit && !m_sdir) begin
         m_valid[idx] = 0;
         m_dirty[idx] = 0;
      end
      if (co != 2'b00 && !rty) begin
         case (co)
            2'b01: begin m_valid[cidx] = 1; m_dirty[cidx] = 0; m_tag[cidx] = ca[31:10]; end
            2'b10: begin m_valid[cidx] = 0; m_dirty[cidx] = 0; end
            default: m_dirty[cidx] = m_valid[cidx];
         endcase
      end
      m_sv = bv;
      if (bv) begin m_sdir = bd; m_saddr = ba; end
   endtask

   task automatic idle(string tag);
      step(0, 0, 32'h0, 2'b00, 32'h0, tag);
   endtask

   localparam logic [31:0] A  = 32'h0000_1230;  // idx 0x23
   localparam logic [31:0] B  = 32'h0004_5670;  // idx 0x27
   localparam logic [31:0] C  = 32'h0008_1230;  // idx 0x23, other tag
   localparam logic [31:0] D  = 32'h0010_0100;  // idx 0x10
   localparam logic [31:0] E  = 32'h0020_03F0;  // idx 0x3F
   localparam logic [31:0] F2 = 32'h0030_0110;  // idx 0x11

   initial begin
      for (int i = 0; i < 64; i++) begin m_valid[i] = 0; m_dirty[i] = 0; m_tag[i] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: idle outputs after reset, empty tags miss
      #5;
      check("R1", cmd_valid, 0);
      check("R1", mem_inhibit, 0);
      check("R1", cpu_retry, 0);
      step(1, 1, A, 2'b00, 32'h0, "R1");
      idle("R1");
      // R3: DMA input hit updates and line stays valid
      step(0, 0, 32'h0, 2'b01, A, "R7");
      step(1, 1, A, 2'b00, 32'h0, "R2");
      step(1, 1, A, 2'b00, 32'h0, "R3");
      idle("R3");
      // R6: same index, other tag misses
      step(1, 1, C, 2'b00, 32'h0, "R6");
      idle("R6");
      // R4: write-through output hit invalidates
      wb_mode = 1'b0;
      step(1, 0, A, 2'b00, 32'h0, "R4");
      step(1, 0, A, 2'b00, 32'h0, "R4");
      idle("R4");
      // R5/R10/R9: write-back supply of a modified line
      wb_mode = 1'b1;
      step(0, 0, 32'h0, 2'b01, B, "R7");
      step(0, 0, 32'h0, 2'b11, B, "R7");
      step(1, 0, B, 2'b00, 32'h0, "R5");
      step(1, 0, B, 2'b00, 32'h0, "R5");
      idle("R5");
      // R7: fill in the same cycle as the bus request is seen next cycle
      step(1, 1, E, 2'b01, E, "R7");
      idle("R7");
      // R8: collision on the judged line, processor loses
      step(0, 0, 32'h0, 2'b01, D, "R7");
      step(1, 0, D, 2'b00, 32'h0, "R8");
      step(0, 0, 32'h0, 2'b10, D, "R8");
      step(0, 0, 32'h0, 2'b01, D, "R8");
      step(1, 1, D, 2'b00, 32'h0, "R8");
      step(0, 0, 32'h0, 2'b01, F2, "R8");
      idle("R8");
      // collision on a miss proceeds
      step(1, 1, 32'h0990_0100, 2'b00, 32'h0, "R6");
      step(0, 0, 32'h0, 2'b10, D, "R8");
      step(1, 1, D, 2'b00, 32'h0, "R8");
      idle("R8");
      // back-to-back snoops in both modes with random processor traffic
      for (int n = 0; n < 600; n++) begin
         logic [31:0] ra, rc;
         if (n % 100 == 0) wb_mode = ~wb_mode;
         ra = {20'h0, 2'($urandom_range(0, 1)), 4'h0, 2'($urandom_range(0, 3)), 4'h0};
         rc = {20'h0, 2'($urandom_range(0, 1)), 4'h0, 2'($urandom_range(0, 3)), 4'h0};
         step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), ra,
              2'($urandom_range(0, 3)), rc, "R2");
      end
      idle("R2");
      if (!done) begin
         done = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule